// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block gathers up to 64 interrupt inputs, each configured by its own control byte, and raises one interrupt request line together with the number of the source that wins arbitration. Each input is synchronised through two flops. It is then treated either as an active-high level or as an edge event. Edge events stay latched in a status array until software writes a one to clear them.

Software sets each source's enable and trigger type through a small register port. It chooses fixed or rotating priority through a global control bit. It acknowledges an interrupt by reading the active-source index register. Under rotating priority, that read moves the search start to the source just above the one that was acknowledged.

Top module: `vecint_ctrl`

## Requirements
- R1: After a synchronous reset, every control byte is 0x00 (disabled, level trigger), rotating priority is off, all status bits read 0, `irq_o` is low and `irq_idx` is 0.
- R2: The control byte of source i sits at byte address 0x40+i, in byte lane i mod 4 of the 32-bit word at 0x40+4*(i/4). Only lanes whose `bus_be` bit is set are written, and the bytes read back unchanged. Bit 3 is the enable and bits 5:4 are the trigger (0 level, 1 rising, 2 falling, 3 both edges).
- R3: A level-triggered source is pending exactly while its synchronised input is high and its enable is set. An input change reaches `irq_o` on the third rising clock edge after it.
- R4: A rising-edge source latches its pending bit on a 0-to-1 transition of the synchronised input, and the bit stays set after the input falls.
- R5: A falling-edge source latches its pending bit on a 1-to-0 transition of the synchronised input.
- R6: Trigger code 3 latches on either transition.
- R7: A write to a status word clears the latched edge of every source whose data bit is 1 and leaves the others unchanged. An edge detected in the same cycle as the clear wins, and the bit stays set.
- R8: A disabled source never drives `irq_o`. A disabled edge source still latches and shows its status bit, and it raises `irq_o` once it is enabled. A disabled level source reads 0 in status.
- R9: With rotating priority off, `irq_idx` is the lowest-numbered source that is both pending and enabled.
- R10: Bit 6 of the global control word at 0x20 selects rotating priority. The search then begins at the source one above the last acknowledged winner and wraps from 63 to 0. The start pointer resets to 63.
- R11: A read of address 0x00 returns the current `irq_idx` in bits 5:0. If `irq_o` is high during that read, the read acknowledges the winner and loads it into the rotation pointer. Otherwise the pointer is unchanged.
- R12: `irq_o` and `irq_idx` are registered. They reflect the pending and enabled sources one clock later, and `irq_idx` is 0 when nothing is pending.
- R13: The status word at 0x80 holds sources 0 to 31 and the word at 0x84 holds sources 32 to 63, with bit n standing for source 32*w+n.
- R14: `bus_rdata` is registered and is zero in any cycle not preceded by a read. Unmapped addresses read zero, and writing a one to the status bit of a level source has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 64 | Raw interrupt inputs, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte lane enables for control-byte writes |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Interrupt request |
| irq_idx | output | 6 | Number of the winning source |

## Verification
The bench aims at the race where a status clear lands in the same cycle as a fresh edge. A design that lets the clear win would drop a real event and read the bit back as zero. It checks that a disabled edge source still latches while a disabled level source does not. Swapping these would either lose edges or leak masked levels onto the line. It walks the rotating pointer through acknowledge reads across the wrap point. An off-by-one start, or a pointer that moves on reads made while idle, shows up as a wrong index sequence. It also checks partial byte-lane writes, so a design that ignores the lane enables clobbers neighbouring sources' control bytes.

// File: rtl/vecint_pkg.sv
package vecint_pkg;
  typedef enum logic [1:0] {
    TRG_LEVEL = 2'd0,
    TRG_RISE  = 2'd1,
    TRG_FALL  = 2'd2,
    TRG_BOTH  = 2'd3
  } trig_e;

  localparam int CB_EN  = 3;
  localparam int CB_TRG = 4;
  localparam int GC_ROT = 6;

  localparam logic [7:0] A_INDEX = 8'h00;
  localparam logic [7:0] A_GCTL  = 8'h20;
  localparam logic [7:0] A_CTL   = 8'h40;
  localparam logic [7:0] A_STAT  = 8'h80;
endpackage

// File: rtl/vecint_src.sv
module vecint_src
  import vecint_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  raw,
  input  logic  en,
  input  trig_e trig,
  input  logic  clr,
  output logic  pend
);
  logic s1, s2, s3, lat;
  logic edge_mode, hit;

  always_comb begin
    edge_mode = (trig != TRG_LEVEL);
    hit = (trig[0] & s2 & ~s3) | (trig[1] & ~s2 & s3);
    pend = edge_mode ? lat : (s2 & en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
      lat <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      s3 <= s2;
      if (!edge_mode)
        lat <= 1'b0;
      else if (hit)
        lat <= 1'b1;
      else if (clr)
        lat <= 1'b0;
    end
  end
endmodule

// File: rtl/vecint_pick.sv
module vecint_pick #(
  parameter int NSRC = 64,
  localparam int IW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] req,
  input  logic            rot,
  input  logic [IW-1:0]   ptr,
  output logic            any,
  output logic [IW-1:0]   win
);
  int start;

  always_comb begin
    any = 1'b0;
    win = '0;
    start = 0;
    if (rot)
      start = (int'(ptr) == NSRC - 1) ? 0 : int'(ptr) + 1;
    for (int k = 0; k < NSRC; k++) begin
      int j;
      j = (start + k) % NSRC;
      if (!any && req[j]) begin
        any = 1'b1;
        win = IW'(j);
      end
    end
  end
endmodule

// File: rtl/vecint_ctrl.sv
module vecint_ctrl
  import vecint_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int AW   = 8,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NSRC),
  localparam int BPW = DW / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [BPW-1:0]  bus_be,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o,
  output logic [IW-1:0]   irq_idx
);
  localparam int NWORD = (NSRC + DW - 1) / DW;
  localparam logic [AW-1:0] AD_IDX  = AW'(A_INDEX);
  localparam logic [AW-1:0] AD_GCTL = AW'(A_GCTL);
  localparam logic [AW-1:0] AD_CTL  = AW'(A_CTL);
  localparam logic [AW-1:0] AD_STAT = AW'(A_STAT);

  logic [7:0]          ctl_q [NSRC];
  logic                rot_q, irq_q;
  logic [IW-1:0]       ptr_q, idx_q;
  logic [DW-1:0]       rdata_q, rd_nxt;
  logic [NSRC-1:0]     pend, en_v, cand, clr_v;
  logic [NWORD*DW-1:0] pend_w, clr_w;
  logic                hit_ctl, any_w, ack;
  logic [IW-1:0]       cbase, win_w;
  logic [AW-1:0]       cofs;

  always_comb begin
    cofs = bus_addr - AD_CTL;
    hit_ctl = (bus_addr >= AD_CTL) && (int'(cofs) < NSRC);
    cbase = IW'(cofs & ~AW'(BPW - 1));
    ack = bus_rd && (bus_addr == AD_IDX) && irq_q;
    pend_w = (NWORD*DW)'(pend);
    for (int w = 0; w < NWORD; w++)
      clr_w[w*DW +: DW] = (bus_wr && bus_addr == AD_STAT + AW'(4*w)) ? bus_wdata : '0;
    clr_v = clr_w[NSRC-1:0];
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign en_v[g] = ctl_q[g][CB_EN];
    vecint_src u_src (
      .clk  (clk),
      .rst  (rst),
      .raw  (src_in[g]),
      .en   (ctl_q[g][CB_EN]),
      .trig (trig_e'(ctl_q[g][CB_TRG +: 2])),
      .clr  (clr_v[g]),
      .pend (pend[g])
    );
  end

  assign cand = pend & en_v;

  vecint_pick #(.NSRC(NSRC)) u_pick (
    .req (cand),
    .rot (rot_q),
    .ptr (ptr_q),
    .any (any_w),
    .win (win_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) ctl_q[i] <= '0;
    end else if (bus_wr && hit_ctl) begin
      for (int l = 0; l < BPW; l++)
        if (bus_be[l]) ctl_q[cbase + IW'(l)] <= bus_wdata[8*l +: 8];
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (bus_addr == AD_IDX)
      rd_nxt = DW'(idx_q);
    else if (bus_addr == AD_GCTL)
      rd_nxt[GC_ROT] = rot_q;
    else if (hit_ctl) begin
      for (int l = 0; l < BPW; l++)
        rd_nxt[8*l +: 8] = ctl_q[cbase + IW'(l)];
    end else begin
      for (int w = 0; w < NWORD; w++)
        if (bus_addr == AD_STAT + AW'(4*w)) rd_nxt = pend_w[w*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rot_q   <= 1'b0;
      ptr_q   <= IW'(NSRC - 1);
      irq_q   <= 1'b0;
      idx_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_wr && bus_addr == AD_GCTL && bus_be[0]) rot_q <= bus_wdata[GC_ROT];
      if (ack) ptr_q <= idx_q;
      irq_q   <= any_w;
      idx_q   <= win_w;
      rdata_q <= bus_rd ? rd_nxt : '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
  assign irq_idx   = idx_q;
endmodule

// File: rtl/vecint_ctrl_chk.sv
module vecint_ctrl_chk #(
  parameter int NSRC = 64,
  parameter int AW   = 8,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_rdata,
  input logic            irq_o,
  input logic [IW-1:0]   irq_idx,
  input logic [NSRC-1:0] cand,
  input logic            rot_q,
  input logic [IW-1:0]   ptr_q
);
  logic [NSRC-1:0] below;
  assign below = (NSRC'(1) << irq_idx) - NSRC'(1);

  p_idle_idx_r12: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> irq_idx == '0);

  p_irq_follows_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_o == (|$past(cand)));

  p_win_pending_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((($past(cand)) >> irq_idx) & NSRC'(1)) != '0);

  p_fixed_lowest_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !$past(rot_q)) |-> (($past(cand)) & below) == '0);

  p_ack_ptr_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == '0 && irq_o) |=> ptr_q == $past(irq_idx));

  p_rot_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == AW'(8'h20)) |=> $stable(rot_q));

  p_rdata_idle_r14: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);
endmodule

bind vecint_ctrl vecint_ctrl_chk #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .irq_idx   (irq_idx),
  .cand      (cand),
  .rot_q     (rot_q),
  .ptr_q     (ptr_q)
);

// File: tb/vecint_ctrl_test.sv
module vecint_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_in = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [5:0]  irq_idx;

  int total = 0, bad = 0;
  bit cmp_on = 0, done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  vecint_ctrl uut (
    .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .irq_idx(irq_idx)
  );

  // behavioural reference model
  bit [63:0] m_s1, m_s2, m_s3, m_lat;
  bit [7:0]  m_ctl [64];
  bit        m_rot, m_irq;
  int        m_ptr, m_idx;
  bit [31:0] m_rdata;

  always @(posedge clk) begin : model
    bit [63:0] pend, cand;
    bit any, en, hit, clr;
    bit [1:0] tr;
    int w, start, a, base;
    bit [31:0] nrd;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_lat = 0;
      foreach (m_ctl[i]) m_ctl[i] = 0;
      m_rot = 0; m_irq = 0; m_ptr = 63; m_idx = 0; m_rdata = 0;
    end else begin
      for (int i = 0; i < 64; i++) begin
        en = m_ctl[i][3]; tr = m_ctl[i][5:4];
        pend[i] = (tr == 0) ? (m_s2[i] & en) : m_lat[i];
        cand[i] = pend[i] & en;
      end
      any = 0; w = 0;
      start = m_rot ? (m_ptr + 1) % 64 : 0;
      for (int k = 0; k < 64; k++)
        if (!any && cand[(start + k) % 64]) begin any = 1; w = (start + k) % 64; end
      a = bus_addr; nrd = 0;
      if (bus_rd) begin
        if (a == 0) nrd = m_idx;
        else if (a == 32) nrd = {25'd0, m_rot, 6'd0};
        else if (a >= 64 && a < 128) begin
          base = (a - 64) & ~3;
          nrd = {m_ctl[base+3], m_ctl[base+2], m_ctl[base+1], m_ctl[base]};
        end else if (a == 128) nrd = pend[31:0];
        else if (a == 132) nrd = pend[63:32];
      end
      if (bus_rd && a == 0 && m_irq) m_ptr = m_idx;
      for (int i = 0; i < 64; i++) begin
        tr = m_ctl[i][5:4];
        hit = (tr[0] && m_s2[i] && !m_s3[i]) || (tr[1] && !m_s2[i] && m_s3[i]);
        clr = bus_wr && a == 128 + 4 * (i / 32) && bus_wdata[i % 32];
        if (tr == 0) m_lat[i] = 0;
        else if (hit) m_lat[i] = 1;
        else if (clr) m_lat[i] = 0;
      end
      m_irq = any; m_idx = w; m_rdata = nrd;
      if (bus_wr) begin
        if (a == 32 && bus_be[0]) m_rot = bus_wdata[6];
        if (a >= 64 && a < 128)
          for (int l = 0; l < 4; l++)
            if (bus_be[l]) m_ctl[((a - 64) & ~3) + l] = bus_wdata[8*l +: 8];
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = src_in;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk({cur_req, " irq_o"}, 32'(irq_o), 32'(m_irq));
    chk({cur_req, " irq_idx"}, 32'(irq_idx), 32'(m_idx));
    chk({cur_req, " rdata"}, bus_rdata, m_rdata);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 0; bus_be = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  logic [31:0] v;

  initial begin
    idle(3);
    rst = 0;
    cmp_on = 1;
    idle(1);

    cur_req = "R1";
    chk("R1 irq after reset", 32'(irq_o), 0);
    rd(8'h80, v); chk("R1 status lo", v, 0);
    rd(8'h7C, v); chk("R1 ctl word", v, 0);
    rd(8'h20, v); chk("R1 gctl", v, 0);

    cur_req = "R2";
    wr(8'h40, 32'h3A281808, 4'hF);
    rd(8'h40, v); chk("R2 ctl readback", v, 32'h3A281808);
    wr(8'h40, 32'h0000FF00, 4'b0010);
    rd(8'h40, v); chk("R2 lane write", v, 32'h3A28FF08);
    wr(8'h40, 0, 4'hF);

    cur_req = "R3";
    wr(8'h44, 32'h00000800, 4'b0010);
    src_in[5] = 1; idle(4);
    chk("R3 level irq", 32'(irq_o), 1);
    chk("R3 level idx", 32'(irq_idx), 5);
    cur_req = "R13";
    rd(8'h80, v); chk("R13 status bit5", v, 32'h20);
    cur_req = "R14";
    wr(8'h80, 32'h20, 4'hF); idle(1);
    rd(8'h80, v); chk("R14 level w1c ignored", v, 32'h20);
    rd(8'h24, v); chk("R14 unmapped", v, 0);
    cur_req = "R3";
    src_in[5] = 0; idle(4);
    chk("R3 level drop", 32'(irq_o), 0);

    cur_req = "R8";
    src_in[6] = 1; idle(4);
    chk("R8 disabled level", 32'(irq_o), 0);
    rd(8'h80, v); chk("R8 disabled level status", v, 0);
    src_in[6] = 0;

    cur_req = "R4";
    wr(8'h60, 32'h00001800, 4'b0010);       // source 33 rising
    src_in[33] = 1; idle(2); src_in[33] = 0; idle(4);
    chk("R4 rising latched", 32'(irq_o), 1);
    cur_req = "R13";
    rd(8'h84, v); chk("R13 status bit33", v, 32'h2);

    cur_req = "R7";
    wr(8'h84, 32'h0, 4'hF); idle(1);
    rd(8'h84, v); chk("R7 zero keeps", v, 32'h2);
    wr(8'h84, 32'h2, 4'hF); idle(1);
    rd(8'h84, v); chk("R7 one clears", v, 0);
    src_in[33] = 1; idle(2);
    wr(8'h84, 32'h2, 4'hF);                  // clear in the cycle the edge latches
    idle(1);
    rd(8'h84, v); chk("R7 set beats clear", v, 32'h2);
    src_in[33] = 0;
    for (int off = 0; off < 5; off++) begin
      wr(8'h84, 32'h2, 4'hF);
      src_in[33] = ~src_in[33];
      idle(off);
      wr(8'h84, 32'h2, 4'hF);
      idle(3);
    end
    src_in[33] = 0; wr(8'h84, 32'h2, 4'hF); idle(3);

    cur_req = "R5";
    wr(8'h68, 32'h00000028, 4'b0001);       // source 40 falling
    src_in[40] = 1; idle(4);
    rd(8'h84, v); chk("R5 no latch on rise", v, 0);
    src_in[40] = 0; idle(4);
    rd(8'h84, v); chk("R5 falling latched", v, 32'h100);
    wr(8'h84, 32'h100, 4'hF);

    cur_req = "R6";
    wr(8'h68, 32'h00003800, 4'b0010);       // source 41 both edges
    src_in[41] = 1; idle(4);
    rd(8'h84, v); chk("R6 rise latched", v, 32'h200);
    wr(8'h84, 32'h200, 4'hF);
    src_in[41] = 0; idle(4);
    rd(8'h84, v); chk("R6 fall latched", v, 32'h200);
    wr(8'h84, 32'h200, 4'hF);

    cur_req = "R8";
    wr(8'h68, 32'h00100000, 4'b0100);       // source 42 rising, disabled
    src_in[42] = 1; idle(4);
    chk("R8 disabled edge no irq", 32'(irq_o), 0);
    rd(8'h84, v); chk("R8 disabled edge status", v, 32'h400);
    wr(8'h68, 32'h00180000, 4'b0100);
    idle(3);
    chk("R8 enable raises irq", 32'(irq_o), 1);
    chk("R8 enable idx", 32'(irq_idx), 42);

    for (int k = 0; k < 16; k++) wr(8'(64 + 4*k), 0, 4'hF);
    src_in = '0; idle(4);
    cur_req = "R12";
    chk("R12 idle idx", 32'(irq_idx), 0);
    rd(8'h00, v); chk("R12 idle read no ack", v, 0);

    cur_req = "R9";
    wr(8'h40, 32'h08000000, 4'b1000);       // source 3
    wr(8'h48, 32'h00080000, 4'b0100);       // source 10
    wr(8'h54, 32'h00000008, 4'b0001);       // source 20
    src_in[3] = 1; src_in[10] = 1; src_in[20] = 1;
    idle(4);
    chk("R9 lowest wins", 32'(irq_idx), 3);
    cur_req = "R11";
    rd(8'h00, v); chk("R11 index read", v, 3);
    idle(2);
    chk("R9 fixed holds", 32'(irq_idx), 3);

    cur_req = "R10";
    wr(8'h20, 32'h40, 4'h1); idle(2);
    rd(8'h20, v); chk("R10 gctl readback", v, 32'h40);
    chk("R10 start above pointer", 32'(irq_idx), 10);
    rd(8'h00, v); chk("R10 ack 10", v, 10); idle(1);
    rd(8'h00, v); chk("R10 ack 20", v, 20); idle(1);
    rd(8'h00, v); chk("R10 wrap ack 3", v, 3); idle(1);
    rd(8'h00, v); chk("R10 ack 10 again", v, 10); idle(1);
    src_in[3] = 0; src_in[10] = 0; src_in[20] = 0;
    idle(4);
    cur_req = "R11";
    rd(8'h00, v); chk("R11 idle read", v, 0);
    src_in[10] = 1; src_in[20] = 1; idle(4);
    chk("R11 pointer kept", 32'(irq_idx), 20);

    cur_req = "R1";
    rst = 1; idle(2); rst = 0; idle(1);
    chk("R1 irq after re-reset", 32'(irq_o), 0);
    rd(8'h20, v); chk("R1 rotate off", v, 0);

    cmp_on = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule